// File: doc/BRIEF.md
# Sleep-State and Wakeup Sequencer

This block decides which clocks a small controller keeps running in each of its three power states: running, idle and deep sleep. Software asks for a sleep state with a one-cycle request strobe and a two-bit mode code. While the request is accepted, the block takes a snapshot of the sleep configuration. From then on it drives the gate enables for the core clock, the PLL, the peripheral clock, the oscillator and the interval-timer clock. It also drives a high-impedance request for the analog outputs. It watches the wake sources that the current state allows and ends the sleep when one of them fires.

Leaving idle is immediate because the PLL never stopped. Leaving deep sleep passes through a lock-wait state. In that state the PLL and oscillator are turned on again, and the core clock stays gated until a programmable count has run out. Every interrupt wake raises a "resume at next instruction" level for the CPU. This level tells the CPU to continue after the sleep instruction rather than at the reset vector. A hardware reset or a power cycle, both seen on the asynchronous reset input, returns every register to its default.

The external wake pin is ignored for a short guard window just after deep sleep begins. This keeps a low level present at entry from ending the sleep at once.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, state_o is 0 (running). The core, PLL, peripheral, oscillator and timer enables are 1. analog_hiz_o, wake_o and resume_next_o are 0.
- R2: In the running state, req_valid_i with req_mode_i = 2'b01 enters idle (state_o = 1) and req_mode_i = 2'b10 enters deep sleep (state_o = 2). Each change is visible right after the sampling edge. Codes 2'b00 and 2'b11 are ignored, and so is any request made outside the running state.
- R3: In idle the core enable is 0. The PLL, peripheral, oscillator and timer enables are 1, and analog_hiz_o is 0.
- R4: Idle ends only on irq_any_i. The block then returns to the running state at that edge with wake_o high. The timer and serial inputs alone do not end idle.
- R5: In deep sleep the core, PLL and peripheral enables are 0 and analog_hiz_o is 1. The oscillator enable is the inverse of the cfg_osc_stop_i value captured at entry. The timer enable is 1 only when the captured cfg_tic_keep_i is 1 and the oscillator runs.
- R6: Deep sleep ends on irq_tic_i while the timer clock runs, on irq_ser_i if cfg_ser_arm_i was 1 at entry, or on ext_wake_ni low if cfg_ext_arm_i was 1 at entry. irq_any_i and unarmed or gated sources are ignored.
- R7: Once deep sleep is entered, the pin ext_wake_ni is ignored at the first GUARD_CYC edges (default 2). It can end the sleep from the following edge on.
- R8: A wake from deep sleep moves to the lock state (state_o = 3). In that state the PLL, oscillator and timer enables are 1, the core and peripheral enables are 0, and analog_hiz_o stays 1. The running state follows N+1 edges later, where N is the cfg_lock_wait_i value captured at entry.
- R9: wake_o is high for exactly the one cycle after the edge that leaves a sleep state. resume_next_o rises with it and holds until the next accepted request.
- R10: Asserting rst_ni from any state, including deep sleep, restores the R1 values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset (pin reset or power cycle) |
| req_valid_i | input | 1 | Sleep request strobe from the control register write |
| req_mode_i | input | 2 | Requested state: 01 idle, 10 deep sleep |
| cfg_osc_stop_i | input | 1 | Stop the oscillator during deep sleep |
| cfg_tic_keep_i | input | 1 | Keep the interval timer clocked during deep sleep |
| cfg_ser_arm_i | input | 1 | Arm serial-port wake from deep sleep |
| cfg_ext_arm_i | input | 1 | Arm external-pin wake from deep sleep |
| cfg_lock_wait_i | input | LOCK_W | PLL lock wait in cycles, applied after deep sleep |
| irq_any_i | input | 1 | Summary of enabled interrupts |
| irq_tic_i | input | 1 | Interval-timer interrupt |
| irq_ser_i | input | 1 | Serial-port interrupt |
| ext_wake_ni | input | 1 | External interrupt pin, active low |
| state_o | output | 2 | 0 run, 1 idle, 2 deep sleep, 3 lock wait |
| core_clk_en_o | output | 1 | Core clock gate enable |
| pll_en_o | output | 1 | PLL enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| tic_clk_en_o | output | 1 | Interval-timer clock enable |
| analog_hiz_o | output | 1 | Put the analog outputs in high impedance |
| wake_o | output | 1 | One-cycle wake event |
| resume_next_o | output | 1 | Continue after the sleep instruction |

## Verification
Every output is decoded from registers, so any input sampled at one rising edge shows its effect right after that edge. The one exception is reset, which acts at once. Lock-wait exits come N+1 edges after the wake edge, and the pin becomes live GUARD_CYC+1 edges after entry. The bench gives each expected vector the index of the edge after which it is due. The monitor compares it at the falling edge that follows that rising edge, so an early or a late transition both show up as a mismatch.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_IDLE  = 2'd1,
        PS_PDOWN = 2'd2,
        PS_LOCK  = 2'd3
    } pstate_e;

    localparam logic [1:0] REQ_IDLE  = 2'b01;
    localparam logic [1:0] REQ_PDOWN = 2'b10;

    // configuration snapshot taken when a sleep request is accepted
    typedef struct packed {
        logic osc_stop;
        logic tic_keep;
        logic ser_arm;
        logic ext_arm;
    } sleep_cfg_t;

endpackage

// File: rtl/pwr_gate_map.sv
module pwr_gate_map
    import pwr_pkg::*;
(
    input  pstate_e    state_i,
    input  sleep_cfg_t cfg_i,
    output logic       core_en_o,
    output logic       pll_en_o,
    output logic       periph_en_o,
    output logic       osc_en_o,
    output logic       tic_en_o,
    output logic       hiz_o
);

    always_comb begin
        core_en_o   = 1'b1;
        pll_en_o    = 1'b1;
        periph_en_o = 1'b1;
        osc_en_o    = 1'b1;
        tic_en_o    = 1'b1;
        hiz_o       = 1'b0;
        unique case (state_i)
            PS_RUN: ;
            PS_IDLE: begin
                core_en_o = 1'b0;
            end
            PS_PDOWN: begin
                core_en_o   = 1'b0;
                pll_en_o    = 1'b0;
                periph_en_o = 1'b0;
                osc_en_o    = ~cfg_i.osc_stop;
                tic_en_o    = cfg_i.tic_keep & ~cfg_i.osc_stop;
                hiz_o       = 1'b1;
            end
            PS_LOCK: begin
                core_en_o   = 1'b0;
                periph_en_o = 1'b0;
                hiz_o       = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval
    import pwr_pkg::*;
(
    input  pstate_e    state_i,
    input  sleep_cfg_t cfg_i,
    input  logic       tic_running_i,
    input  logic       guard_open_i,
    input  logic       irq_any_i,
    input  logic       irq_tic_i,
    input  logic       irq_ser_i,
    input  logic       ext_wake_ni,
    output logic       wake_hit_o
);

    logic pd_tic;
    logic pd_ser;
    logic pd_ext;

    always_comb begin
        pd_tic = irq_tic_i & tic_running_i;
        pd_ser = irq_ser_i & cfg_i.ser_arm;
        pd_ext = ~ext_wake_ni & cfg_i.ext_arm & guard_open_i;
        unique case (state_i)
            PS_IDLE:  wake_hit_o = irq_any_i;
            PS_PDOWN: wake_hit_o = pd_tic | pd_ser | pd_ext;
            default:  wake_hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int LOCK_W    = 8,
    parameter int GUARD_CYC = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [1:0]        req_mode_i,
    input  logic              cfg_osc_stop_i,
    input  logic              cfg_tic_keep_i,
    input  logic              cfg_ser_arm_i,
    input  logic              cfg_ext_arm_i,
    input  logic [LOCK_W-1:0] cfg_lock_wait_i,
    input  logic              irq_any_i,
    input  logic              irq_tic_i,
    input  logic              irq_ser_i,
    input  logic              ext_wake_ni,
    output logic [1:0]        state_o,
    output logic              core_clk_en_o,
    output logic              pll_en_o,
    output logic              periph_clk_en_o,
    output logic              osc_en_o,
    output logic              tic_clk_en_o,
    output logic              analog_hiz_o,
    output logic              wake_o,
    output logic              resume_next_o
);

    localparam int GUARD_W = (GUARD_CYC < 1) ? 1 : $clog2(GUARD_CYC + 1);
    localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(GUARD_CYC);

    typedef struct packed {
        pstate_e           st;
        sleep_cfg_t        cfg;
        logic [LOCK_W-1:0] lock_cnt;
        logic [GUARD_W-1:0] guard;
        logic              wake;
        logic              resume;
    } regs_t;

    regs_t r_d, r_q;

    logic wake_hit;
    logic tic_en;
    logic guard_open;
    logic req_ok;

    assign guard_open = (r_q.guard == '0);
    assign req_ok     = req_valid_i &&
                        (req_mode_i == REQ_IDLE || req_mode_i == REQ_PDOWN);

    pwr_gate_map u_gates (
        .state_i    (r_q.st),
        .cfg_i      (r_q.cfg),
        .core_en_o  (core_clk_en_o),
        .pll_en_o   (pll_en_o),
        .periph_en_o(periph_clk_en_o),
        .osc_en_o   (osc_en_o),
        .tic_en_o   (tic_en),
        .hiz_o      (analog_hiz_o)
    );

    pwr_wake_eval u_wake (
        .state_i      (r_q.st),
        .cfg_i        (r_q.cfg),
        .tic_running_i(tic_en),
        .guard_open_i (guard_open),
        .irq_any_i    (irq_any_i),
        .irq_tic_i    (irq_tic_i),
        .irq_ser_i    (irq_ser_i),
        .ext_wake_ni  (ext_wake_ni),
        .wake_hit_o   (wake_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wake = 1'b0;
        unique case (r_q.st)
            PS_RUN: begin
                if (req_ok) begin
                    r_d.resume       = 1'b0;
                    r_d.cfg.osc_stop = cfg_osc_stop_i;
                    r_d.cfg.tic_keep = cfg_tic_keep_i;
                    r_d.cfg.ser_arm  = cfg_ser_arm_i;
                    r_d.cfg.ext_arm  = cfg_ext_arm_i;
                    r_d.lock_cnt     = cfg_lock_wait_i;
                    r_d.guard        = GUARD_LOAD;
                    r_d.st           = (req_mode_i == REQ_IDLE) ? PS_IDLE : PS_PDOWN;
                end
            end
            PS_IDLE: begin
                if (wake_hit) begin
                    r_d.st     = PS_RUN;
                    r_d.wake   = 1'b1;
                    r_d.resume = 1'b1;
                end
            end
            PS_PDOWN: begin
                if (wake_hit) begin
                    r_d.st     = PS_LOCK;
                    r_d.wake   = 1'b1;
                    r_d.resume = 1'b1;
                end else if (!guard_open) begin
                    r_d.guard = r_q.guard - 1'b1;
                end
            end
            PS_LOCK: begin
                if (r_q.lock_cnt == '0) begin
                    r_d.st = PS_RUN;
                end else begin
                    r_d.lock_cnt = r_q.lock_cnt - 1'b1;
                end
            end
            default: r_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o       = r_q.st;
    assign tic_clk_en_o  = tic_en;
    assign wake_o        = r_q.wake;
    assign resume_next_o = r_q.resume;

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] state_o,
    input logic       core_clk_en_o,
    input logic       pll_en_o,
    input logic       periph_clk_en_o,
    input logic       osc_en_o,
    input logic       tic_clk_en_o,
    input logic       analog_hiz_o,
    input logic       wake_o,
    input logic       resume_next_o
);

    // R3
    idle_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 2'd1 |-> !core_clk_en_o && pll_en_o && periph_clk_en_o
                            && osc_en_o && !analog_hiz_o);

    // R5
    pdown_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 2'd2 |-> !core_clk_en_o && !pll_en_o && !periph_clk_en_o
                            && analog_hiz_o);

    // R5
    tic_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tic_clk_en_o |-> osc_en_o);

    // R8
    lock_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 2'd3 |-> !core_clk_en_o && pll_en_o && osc_en_o && analog_hiz_o);

    // R8
    core_after_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_clk_en_o) |-> $past(pll_en_o));

    // R9
    wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    // R9
    wake_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> resume_next_o);

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_o        (state_o),
    .core_clk_en_o  (core_clk_en_o),
    .pll_en_o       (pll_en_o),
    .periph_clk_en_o(periph_clk_en_o),
    .osc_en_o       (osc_en_o),
    .tic_clk_en_o   (tic_clk_en_o),
    .analog_hiz_o   (analog_hiz_o),
    .wake_o         (wake_o),
    .resume_next_o  (resume_next_o)
);

// File: tb/sim_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_sleep_ctrl;

    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_mode = 2'b00;
    logic          c_osc = 1'b0, c_tic = 1'b0, c_ser = 1'b0, c_ext = 1'b0;
    logic [LW-1:0] c_lock = '0;
    logic          i_any = 1'b0, i_tic = 1'b0, i_ser = 1'b0, ext_n = 1'b1;
    logic [1:0]    st;
    logic          core, pll, per, osc, tic, hiz, wk, res;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int         due;
        logic [9:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_sleep_ctrl #(.LOCK_W(LW), .GUARD_CYC(2)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
        .cfg_osc_stop_i(c_osc), .cfg_tic_keep_i(c_tic), .cfg_ser_arm_i(c_ser),
        .cfg_ext_arm_i(c_ext), .cfg_lock_wait_i(c_lock), .irq_any_i(i_any),
        .irq_tic_i(i_tic), .irq_ser_i(i_ser), .ext_wake_ni(ext_n),
        .state_o(st), .core_clk_en_o(core), .pll_en_o(pll), .periph_clk_en_o(per),
        .osc_en_o(osc), .tic_clk_en_o(tic), .analog_hiz_o(hiz), .wake_o(wk),
        .resume_next_o(res)
    );

    function automatic logic [9:0] vec(input logic [1:0] s, input logic c, p, q, o, t,
                                       input logic h, w, r);
        return {s, c, p, q, o, t, h, w, r};
    endfunction

    function automatic logic [9:0] actual();
        return {st, core, pll, per, osc, tic, hiz, wk, res};
    endfunction

    task automatic compare(input logic [9:0] exp, input string tag);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, actual(), exp);
        end
    endtask

    // driver: inputs already set; expected vector is due after the next rising edge
    task automatic tick(input logic [9:0] exp, input string tag);
        item_t it;
        it.due = cyc + 1;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                compare(it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [9:0] RUN0 = 10'b00_11111_0_0_0;

    initial begin
        repeat (3) @(negedge clk);
        compare(RUN0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        tick(RUN0, "R1 after release");

        // idle entry and wake rules
        req_valid = 1; req_mode = 2'b01;
        tick(vec(2'd1,0,1,1,1,1,0,0,0), "R2 R3 idle entry");
        req_valid = 0; i_ser = 1; i_tic = 1;
        req_mode = 2'b10; req_valid = 1;
        tick(vec(2'd1,0,1,1,1,1,0,0,0), "R4 R2 idle ignores ser/tic/request");
        req_valid = 0; i_ser = 0; i_tic = 0; i_any = 1;
        tick(vec(2'd0,1,1,1,1,1,0,1,1), "R4 R9 idle wake");
        i_any = 0;
        tick(vec(2'd0,1,1,1,1,1,0,0,1), "R9 pulse ends resume held");

        // illegal codes
        req_valid = 1; req_mode = 2'b11;
        tick(vec(2'd0,1,1,1,1,1,0,0,1), "R2 code 11 ignored");
        req_mode = 2'b00;
        tick(vec(2'd0,1,1,1,1,1,0,0,1), "R2 code 00 ignored");

        // deep sleep, oscillator stopped, pin wake with guard
        req_mode = 2'b10; c_osc = 1; c_tic = 1; c_ser = 0; c_ext = 1; c_lock = 8'd3;
        tick(vec(2'd2,0,0,0,0,0,1,0,0), "R5 pdown osc stopped");
        req_valid = 0; c_osc = 0; c_ser = 1; c_lock = 8'd0;
        ext_n = 0; i_tic = 1; i_ser = 1; i_any = 1;
        tick(vec(2'd2,0,0,0,0,0,1,0,0), "R7 R6 guard edge 1, gated sources");
        tick(vec(2'd2,0,0,0,0,0,1,0,0), "R7 guard edge 2");
        i_tic = 0; i_ser = 0; i_any = 0;
        tick(vec(2'd3,0,1,0,1,1,1,1,1), "R7 R8 pin wake into lock");
        ext_n = 1;
        tick(vec(2'd3,0,1,0,1,1,1,0,1), "R8 lock 1");
        tick(vec(2'd3,0,1,0,1,1,1,0,1), "R8 lock 2");
        tick(vec(2'd3,0,1,0,1,1,1,0,1), "R8 lock 3");
        tick(vec(2'd0,1,1,1,1,1,0,0,1), "R8 run after N+1");

        // deep sleep, timer kept, wake by timer, zero lock wait
        req_valid = 1; req_mode = 2'b10; c_osc = 0; c_tic = 1; c_ser = 0; c_ext = 0;
        c_lock = 8'd0;
        tick(vec(2'd2,0,0,0,1,1,1,0,0), "R5 pdown timer kept");
        req_valid = 0; ext_n = 0; i_ser = 1; i_any = 1;
        tick(vec(2'd2,0,0,0,1,1,1,0,0), "R6 unarmed pin/serial ignored");
        tick(vec(2'd2,0,0,0,1,1,1,0,0), "R6 unarmed still ignored");
        tick(vec(2'd2,0,0,0,1,1,1,0,0), "R6 pin past guard unarmed");
        ext_n = 1; i_ser = 0; i_any = 0; i_tic = 1;
        tick(vec(2'd3,0,1,0,1,1,1,1,1), "R6 timer wake");
        i_tic = 0;
        tick(vec(2'd0,1,1,1,1,1,0,0,1), "R8 zero wait");

        // deep sleep with timer off, serial armed
        req_valid = 1; c_osc = 0; c_tic = 0; c_ser = 1; c_lock = 8'd1;
        tick(vec(2'd2,0,0,0,1,0,1,0,0), "R5 timer off");
        req_valid = 0; c_ser = 0; i_tic = 1;
        tick(vec(2'd2,0,0,0,1,0,1,0,0), "R6 timer irq with timer off");
        i_tic = 0; i_ser = 1;
        tick(vec(2'd3,0,1,0,1,1,1,1,1), "R6 serial wake captured arm");
        i_ser = 0;
        tick(vec(2'd3,0,1,0,1,1,1,0,1), "R8 lock wait 1");
        tick(vec(2'd0,1,1,1,1,1,0,0,1), "R8 run");

        // reset during deep sleep
        req_valid = 1; c_osc = 1;
        tick(vec(2'd2,0,0,0,0,0,1,0,0), "R5 pdown again");
        req_valid = 0;
        #1 rst_n = 0;
        #1 compare(RUN0, "R10 reset from pdown");
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tick(RUN0, "R10 after release");
        @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule